// File: doc/BRIEF.md
# Clock divider field encoder

This block turns a requested clock divide ratio into the three 16-bit configuration words that a programmable clock-synthesis counter loads. The ratio arrives as a 7-bit integer part and a 3-bit fraction counted in eighths. A one-cycle `start` pulse presents a request. Two clock edges later the block shows the packed words and pulses `done` for one cycle. The words stay unchanged until the next result comes out.

The integer-only case splits the count into high and low phases plus an odd-count marker. The fractional case applies the corrections that a fractional counter needs: high and low counts reduced by one in some cases, a rising-edge and a falling-edge waveform-adjust bit, and a three-bit phase value. A ratio of exactly one sets only the bypass flag. An inverse decoder rebuilds the ratio in eighths from the held words. Software or a checker can then confirm a setting without knowing the encoding rules. Requests may arrive on consecutive cycles, and each one produces its own result in order.

Top module: `clkdiv_field_enc`

## Requirements
- R1: While reset is high and in the first cycle after it, `done` and `err` are 0, all three words are 0 and `ratio_eighths` is 0.
- R2: A request sampled with `start` high at a clock edge produces `done` high for exactly one cycle after the second edge. Requests on consecutive cycles each yield one result, in order. While `done` is low, the words and `err` keep their values.
- R3: An integer part of 1 gives `ctl_word` = 0x0040, with only the bypass bit 6 set, and `cnt_word` = `phs_word` = 0, whatever the fraction is.
- R4: With fraction 0 and integer part N ≥ 2: high = N/2 (rounded down), odd bit = N mod 2 and low = N − high. No fractional field or adjust bit is set.
- R5: With a nonzero fraction F and N ≥ 2: the fraction enable (bit 11 of `ctl_word`) is 1 and F is stored in bits 14:12. The counts start from high = low = N/2 and odd = N mod 2.
- R6: In fractional mode with N even, high is one less than N/2, the rising-adjust bit (bit 10 of `ctl_word`) is set, and low is one less than N/2.
- R7: In fractional mode with N odd, low is reduced by one only when F = 1. The falling-adjust bit (bit 10 of `phs_word`) is set when exactly one of "N even" and "F = 1" holds, and also when N = 2 and F = 1.
- R8: In fractional mode the phase in `phs_word` bits 13:11 equals 4·(N mod 2) + F/2 (rounded down).
- R9: Field positions: `cnt_word` has high in 11:6 and low in 5:0. `ctl_word` has the odd bit in 7 and the fields given in R3, R5 and R6. `phs_word` has the fields given in R7 and R8. Every other bit is 0.
- R10: `ratio_eighths` decodes the held words. It is 8 if the bypass bit is set. Otherwise it is (high+low)·8, and when the fraction enable is set it adds 8 if the odd bit is set and F ≠ 1, 16 otherwise, and then adds F. For every valid request this equals 8·N + F, or 8 when N = 1.
- R11: A request with N = 0, or with N = 127 and F = 0 (low would not fit in 6 bits), gives all-zero words, `ratio_eighths` = 0 and `err` = 1. A valid request clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, one request per cycle it is high |
| div_int | input | 7 | Integer part N of the divide ratio |
| div_frac | input | 3 | Fractional part F in eighths |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Last result came from an invalid request |
| cnt_word | output | 16 | High and low counts |
| ctl_word | output | 16 | Fraction, enable, adjust, odd and bypass bits |
| phs_word | output | 16 | Fractional phase and falling-adjust bit |
| ratio_eighths | output | 11 | Ratio rebuilt from the held words, in eighths |

## Verification
The hardest case to reach is a run of requests on consecutive cycles. In that case the capture stage and the packing stage each hold a different request at the same time, and a fault in how results are ordered or held shows up only as a wrong word on a later `done`. The stimulus holds `start` high without a gap while it sweeps every integer part from 0 to 127 against every fraction. This covers the N = 2, F = 1 falling-adjust exception, both invalid codes and the largest counts in one unbroken stream. A queue of expected results, each tagged with the cycle it is due, catches any slip.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int INT_W   = 7;
    localparam int FRAC_W  = 3;
    localparam int CNT_W   = 6;
    localparam int WORD_W  = 16;
    localparam int PHASE_W = FRAC_W;
    localparam int RATIO_W = CNT_W + 1 + FRAC_W + 1;
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    localparam int EIGHTHS = 1 << FRAC_W;

    // bit positions the counter decodes
    localparam int LO_LSB    = 0;
    localparam int HI_LSB    = 6;
    localparam int BYP_BIT   = 6;
    localparam int ODD_BIT   = 7;
    localparam int RISE_BIT  = 10;
    localparam int FEN_BIT   = 11;
    localparam int FRAC_LSB  = 12;
    localparam int FALL_BIT  = 10;
    localparam int PH_LSB    = 11;

    typedef struct packed {
        logic [INT_W-1:0]  div;
        logic [FRAC_W-1:0] frac;
    } div_req_t;

    typedef struct packed {
        logic [CNT_W-1:0]   high;
        logic [CNT_W-1:0]   low;
        logic               odd;
        logic               nocount;
        logic               frac_en;
        logic [FRAC_W-1:0]  frac;
        logic               wf_rise;
        logic               wf_fall;
        logic [PHASE_W-1:0] phase;
        logic               invalid;
    } div_fields_t;

    typedef struct packed {
        logic [WORD_W-1:0] cnt_word;
        logic [WORD_W-1:0] ctl_word;
        logic [WORD_W-1:0] phs_word;
    } div_words_t;

    function automatic div_words_t pack_words(input div_fields_t f);
        div_words_t w;
        w = '0;
        w.cnt_word[HI_LSB +: CNT_W]     = f.high;
        w.cnt_word[LO_LSB +: CNT_W]     = f.low;
        w.ctl_word[FRAC_LSB +: FRAC_W]  = f.frac;
        w.ctl_word[FEN_BIT]             = f.frac_en;
        w.ctl_word[RISE_BIT]            = f.wf_rise;
        w.ctl_word[ODD_BIT]             = f.odd;
        w.ctl_word[BYP_BIT]             = f.nocount;
        w.phs_word[PH_LSB +: PHASE_W]   = f.phase;
        w.phs_word[FALL_BIT]            = f.wf_fall;
        return w;
    endfunction

endpackage

// File: rtl/cdf_req_stage.sv
module cdf_req_stage
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [INT_W-1:0]  div_in,
    input  logic [FRAC_W-1:0] frac_in,
    output logic              req_vld,
    output div_req_t          req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_vld <= 1'b0;
            req     <= '0;
        end else begin
            req_vld <= start;
            if (start) begin
                req.div  <= div_in;
                req.frac <= frac_in;
            end
        end
    end

endmodule

// File: rtl/cdf_field_calc.sv
module cdf_field_calc
    import clkdiv_pkg::*;
(
    input  div_req_t    req,
    output div_fields_t fld
);

    logic [CNT_W-1:0] half;
    logic             odd;
    logic [INT_W-1:0] lo_whole;
    logic             frac_any;
    logic             frac_one;
    logic             even_dec;

    always_comb begin
        half     = req.div[INT_W-1:1];
        odd      = req.div[0];
        lo_whole = req.div - INT_W'(half);
        frac_any = |req.frac;
        frac_one = (req.frac == FRAC_W'(1));
        even_dec = ~odd;
    end

    always_comb begin
        fld = '0;
        if (req.div == '0) begin
            fld.invalid = 1'b1;
        end else if (req.div == INT_W'(1)) begin
            fld.nocount = 1'b1;
        end else if (!frac_any) begin
            if (lo_whole > INT_W'(CNT_MAX)) begin
                fld.invalid = 1'b1;
            end else begin
                fld.high = half;
                fld.low  = lo_whole[CNT_W-1:0];
                fld.odd  = odd;
            end
        end else begin
            fld.frac_en = 1'b1;
            fld.frac    = req.frac;
            fld.odd     = odd;
            fld.high    = half - CNT_W'(even_dec);
            fld.wf_rise = even_dec;
            fld.low     = half - CNT_W'(even_dec | frac_one);
            fld.wf_fall = (even_dec ^ frac_one) |
                          ((req.div == INT_W'(2)) & frac_one);
            fld.phase   = {odd, req.frac[FRAC_W-1:1]};
        end
    end

endmodule

// File: rtl/cdf_word_pack.sv
module cdf_word_pack
    import clkdiv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fld_vld,
    input  div_fields_t fld,
    output logic        done,
    output logic        err,
    output div_words_t  words
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            err   <= 1'b0;
            words <= '0;
        end else begin
            done <= fld_vld;
            if (fld_vld) begin
                words <= pack_words(fld);
                err   <= fld.invalid;
            end
        end
    end

endmodule

// File: rtl/cdf_ratio_decode.sv
module cdf_ratio_decode
    import clkdiv_pkg::*;
(
    input  logic [CNT_W-1:0]   high,
    input  logic [CNT_W-1:0]   low,
    input  logic [FRAC_W-1:0]  frac,
    input  logic               frac_en,
    input  logic               odd,
    input  logic               bypass,
    output logic [RATIO_W-1:0] ratio
);

    logic [RATIO_W-1:0] base;
    logic [RATIO_W-1:0] bump;

    always_comb begin
        base = (RATIO_W'(high) + RATIO_W'(low)) << FRAC_W;
        bump = (odd && frac != FRAC_W'(1)) ? RATIO_W'(EIGHTHS)
                                           : RATIO_W'(2 * EIGHTHS);
        if (bypass) begin
            ratio = RATIO_W'(EIGHTHS);
        end else if (frac_en) begin
            ratio = base + bump + RATIO_W'(frac);
        end else begin
            ratio = base;
        end
    end

endmodule

// File: rtl/clkdiv_field_enc.sv
module clkdiv_field_enc
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [INT_W-1:0]   div_int,
    input  logic [FRAC_W-1:0]  div_frac,
    output logic               done,
    output logic               err,
    output logic [WORD_W-1:0]  cnt_word,
    output logic [WORD_W-1:0]  ctl_word,
    output logic [WORD_W-1:0]  phs_word,
    output logic [RATIO_W-1:0] ratio_eighths
);

    logic        req_vld;
    div_req_t    req;
    div_fields_t fld;
    div_words_t  words;

    cdf_req_stage u_req (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .div_in  (div_int),
        .frac_in (div_frac),
        .req_vld (req_vld),
        .req     (req)
    );

    cdf_field_calc u_calc (
        .req (req),
        .fld (fld)
    );

    cdf_word_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .fld_vld (req_vld),
        .fld     (fld),
        .done    (done),
        .err     (err),
        .words   (words)
    );

    cdf_ratio_decode u_dec (
        .high    (words.cnt_word[HI_LSB +: CNT_W]),
        .low     (words.cnt_word[LO_LSB +: CNT_W]),
        .frac    (words.ctl_word[FRAC_LSB +: FRAC_W]),
        .frac_en (words.ctl_word[FEN_BIT]),
        .odd     (words.ctl_word[ODD_BIT]),
        .bypass  (words.ctl_word[BYP_BIT]),
        .ratio   (ratio_eighths)
    );

    assign cnt_word = words.cnt_word;
    assign ctl_word = words.ctl_word;
    assign phs_word = words.phs_word;

endmodule

// File: rtl/clkdiv_field_enc_chk.sv
module clkdiv_field_enc_chk
    import clkdiv_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               done,
    input logic               err,
    input logic [WORD_W-1:0]  cnt_word,
    input logic [WORD_W-1:0]  ctl_word,
    input logic [WORD_W-1:0]  phs_word,
    input logic [RATIO_W-1:0] ratio_eighths
);

    logic [1:0] settle;

    always_ff @(posedge clk) begin
        if (rst) settle <= '0;
        else if (settle != 2'd3) settle <= settle + 2'd1;
    end

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (settle >= 2'd2) |-> (done == $past(start, 2)));

    // R2
    hold_words_chk: assert property (@(posedge clk) disable iff (rst)
        (settle >= 2'd1 && !done) |-> ($stable(cnt_word) && $stable(ctl_word)
                                       && $stable(phs_word) && $stable(err)));

    // R11
    invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (cnt_word == '0 && ctl_word == '0 && phs_word == '0
                 && ratio_eighths == '0));

    // R3
    bypass_only_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_word[BYP_BIT] |-> (ctl_word == WORD_W'(16'h0040) && cnt_word == '0
                               && phs_word == '0
                               && ratio_eighths == RATIO_W'(EIGHTHS)));

    // R5
    frac_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_word[FEN_BIT] |-> (ctl_word[FRAC_LSB +: FRAC_W] != '0));

    // R6
    even_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_word[FEN_BIT] |-> (ctl_word[RISE_BIT] == !ctl_word[ODD_BIT]));

    // R8
    phase_form_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_word[FEN_BIT] |-> (phs_word[PH_LSB + 2] == ctl_word[ODD_BIT] &&
            phs_word[PH_LSB +: 2] == ctl_word[FRAC_LSB + 1 +: 2]));

endmodule

bind clkdiv_field_enc clkdiv_field_enc_chk i_clkdiv_field_enc_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .done          (done),
    .err           (err),
    .cnt_word      (cnt_word),
    .ctl_word      (ctl_word),
    .phs_word      (phs_word),
    .ratio_eighths (ratio_eighths)
);

// File: tb/test_clkdiv_field_enc.sv
`timescale 1ns/1ps
module test_clkdiv_field_enc;

    localparam int WD_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [6:0]  div_int;
    logic [2:0]  div_frac;
    logic        done;
    logic        err;
    logic [15:0] cnt_word;
    logic [15:0] ctl_word;
    logic [15:0] phs_word;
    logic [10:0] ratio_eighths;

    always #2 clk = ~clk;

    clkdiv_field_enc i_clkdiv_field_enc (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .div_int       (div_int),
        .div_frac      (div_frac),
        .done          (done),
        .err           (err),
        .cnt_word      (cnt_word),
        .ctl_word      (ctl_word),
        .phs_word      (phs_word),
        .ratio_eighths (ratio_eighths)
    );

    typedef struct {
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] c;
        logic        e;
        int          ratio;
        int          due;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    exp_t last;
    int   total = 0;
    int   bad   = 0;
    int   cyc   = 0;
    bit   ended = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // expected words from the requirement rules
    function automatic exp_t model(input int d, input int f);
        exp_t x;
        int hi, lo, od, wr, wf, ph;
        x.a = '0; x.b = '0; x.c = '0; x.e = 1'b0;
        x.due = 0;
        if (d == 0 || (d == 127 && f == 0)) begin
            x.e = 1'b1; x.ratio = 0; x.tag = "R11";
            return x;
        end
        if (d == 1) begin
            x.b = 16'h0040; x.ratio = 8; x.tag = "R3";
            return x;
        end
        hi = d / 2; od = d % 2; wr = 0; wf = 0; ph = 0;
        if (f == 0) begin
            lo = d - hi; x.tag = "R4";
        end else begin
            lo = hi;
            if (od == 0) begin hi--; wr = 1; end
            if (od == 0 || f == 1) lo--;
            wf = (((od == 0) != (f == 1)) || (d == 2 && f == 1)) ? 1 : 0;
            ph = od * 4 + f / 2; // R8
            x.tag = (f == 1) ? "R7" : ((od == 0) ? "R6" : "R5");
        end
        x.a = 16'((hi << 6) | lo);
        x.b = 16'((f << 12) | ((f != 0 ? 1 : 0) << 11) | (wr << 10) | (od << 7));
        x.c = 16'((ph << 11) | (wf << 10));
        x.ratio = d * 8 + f;
        return x;
    endfunction

    task automatic issue(input int d, input int f);
        exp_t x;
        @(negedge clk);
        start    = 1'b1;
        div_int  = 7'(d);
        div_frac = 3'(f);
        x = model(d, f);
        x.due = cyc + 2;
        q.push_back(x);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            start = 1'b0;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && done && !ended) begin
            if (q.size() == 0) begin
                chk(1'b0, "R2", "done with no request", 1, 0);
            end else begin
                cur = q.pop_front();
                chk(cyc == cur.due, "R2", "done cycle", cyc, cur.due);
                chk(cnt_word == cur.a, cur.tag, "cnt_word", cnt_word, cur.a);
                chk(ctl_word == cur.b, cur.tag, "ctl_word", ctl_word, cur.b);
                chk(phs_word == cur.c, cur.tag, "phs_word", phs_word, cur.c);
                chk(err == cur.e, "R11", "err", err, cur.e);
                chk(int'(ratio_eighths) == cur.ratio, "R10", "ratio",
                    ratio_eighths, cur.ratio);
                chk(cnt_word[15:12] == 0 && ctl_word[15] == 0 && ctl_word[9:8] == 0
                    && ctl_word[5:0] == (cur.b[6] ? 6'h00 : 6'h00)
                    && phs_word[15:14] == 0 && phs_word[9:0] == 0,
                    "R9", "unused bits", {cnt_word, ctl_word, phs_word}, 0);
                last = cur;
            end
        end
    end

    initial begin
        #(WD_CYCLES * 4);
        if (!ended) begin
            ended = 1;
            chk(1'b0, "R2", "watchdog expired", cyc, WD_CYCLES);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; div_int = '0; div_frac = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 0 && err == 0, "R1", "done/err in reset", {done, err}, 0);
        chk(cnt_word == 0 && ctl_word == 0 && phs_word == 0, "R1", "words in reset",
            {cnt_word, ctl_word, phs_word}, 0);
        chk(ratio_eighths == 0, "R1", "ratio in reset", ratio_eighths, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0 && cnt_word == 0, "R1", "first cycle after reset",
            {done, cnt_word}, 0);

        // directed corners, isolated requests
        issue(1, 0);   idle(3);  // R3
        issue(1, 5);   idle(3);  // R3
        issue(2, 0);   idle(3);  // R4
        issue(5, 0);   idle(3);  // R4
        issue(2, 1);   idle(3);  // R7 special case
        issue(3, 1);   idle(3);  // R7
        issue(3, 2);   idle(3);  // R5
        issue(4, 3);   idle(3);  // R6
        issue(126, 0); idle(3);  // R4 largest integer
        issue(127, 1); idle(3);  // R7
        issue(0, 4);   idle(3);  // R11
        issue(127, 0); idle(3);  // R11
        issue(6, 6);   idle(6);  // R6

        // R2 hold: outputs unchanged while idle
        chk(cnt_word == last.a && ctl_word == last.b && phs_word == last.c
            && err == last.e, "R2", "hold while idle",
            {cnt_word, ctl_word, phs_word}, {last.a, last.b, last.c});
        chk(done == 1'b0, "R2", "done single cycle", done, 0);

        // back-to-back sweep of every request
        for (int d = 0; d < 128; d++) begin
            for (int f = 0; f < 8; f++) begin
                issue(d, f);
            end
        end
        idle(5);
        chk(q.size() == 0, "R2", "results outstanding", q.size(), 0);
        chk(done == 1'b0, "R2", "done low after burst", done, 0);

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule